// File: doc/BRIEF.md
# Serial Receiver with Flag-Tagged Receive Queue

This block receives asynchronous serial characters on a single input line. An external strobe, pulsing sixteen times per bit, sets the sampling rate. Character length, parity, stop-bit count and bit order come from static configuration inputs that match the sending side. Each received character is packed into a 16-bit word: the data sits in the low byte and that character's error flags sit in the high byte.

Two storage modes are available. In single mode, a one-word holding register keeps the most recent character. In queue mode, a 16-word first-in first-out store keeps characters in arrival order. A consumer reads the word at `rd_data` and pulses `rd_en` to release it.

Three one-cycle interrupt pulses report activity. One marks every completed character. One marks a completed character that carries any error flag. The third, in queue mode only, marks a line that has stayed quiet while unread words wait in the queue.

Top module: `serial_rx_tagq`

## Requirements
- R1: A falling edge on the line starts a character only if the line is still low on the 8th strobe after the edge. Otherwise the receiver returns to idle, and no completion pulse or stored word results.
- R2: Data bits are collected LSB-first when `cfg_msb_first`=0 and MSB-first when it is 1. There are 8 data bits when `cfg_len8`=1 and 7 when it is 0. A 7-bit character is zero-extended into bits 7:0, and bits 15:11 of every word read as zero.
- R3: `cfg_parity` selects 00 none, 01 odd, 10 even, or 11 forced-zero. A parity bit that does not match the selected rule sets bit 8 of the word.
- R4: Bit 9 of the word is set when any expected stop bit is sampled low. There is one stop bit, or two when `cfg_two_stop`=1.
- R5: In single mode (`cfg_fifo_mode`=0), a character that completes while the holding register is still unread replaces it, and bit 10 of the new word is set.
- R6: A read accepted in the same cycle that a character completes frees the slot first. In single mode the new word then carries no bit 10. In queue mode a full queue accepts the new word and none is lost.
- R7: In queue mode, up to 16 words are returned in arrival order, each with its own flag bits.
- R8: In queue mode, a character that completes while 16 words wait unread is discarded. Bit 10 is then set on the newest word already in the queue.
- R9: `irq_done` pulses for one cycle per completed character. `irq_err` pulses in the same cycle when that character's word carries bit 8, 9 or 10.
- R10: In queue mode, `irq_timeout` pulses once when the queue is non-empty and the receiver has sat idle for 4 character times, measured from the last completion. A character time is 16 strobes multiplied by the frame length in bits. The pulse never occurs in single mode.
- R11: After reset, `rd_valid`, `rd_data` and all interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Sampling strobe, 16 per bit time |
| rx_line | input | 1 | Serial input line, idle high |
| cfg_fifo_mode | input | 1 | 1 = 16-word queue, 0 = single holding register |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_msb_first | input | 1 | 1 = MSB first on the line |
| cfg_parity | input | 2 | 00 none, 01 odd, 10 even, 11 forced zero |
| cfg_two_stop | input | 1 | 1 = two stop bits expected |
| rd_en | input | 1 | Release the word shown on rd_data |
| rd_data | output | 16 | Oldest unread word: flags in 15:8, data in 7:0 |
| rd_valid | output | 1 | A word is available |
| irq_done | output | 1 | Character completed |
| irq_err | output | 1 | Completed character carries an error flag |
| irq_timeout | output | 1 | Queue-mode idle timeout |

## Verification
The case that needs care is a consumer read that lands in the very cycle in which the stop-bit sample completes a new character. Without the ordering rule, that collision would raise an overrun in single mode or drop a character from a full queue. The strobe is held high every cycle, so the bench counts clock edges from the start-bit edge to the stop-bit sample and raises `rd_en` exactly there, once with a full holding register and once with a full queue. The check is whether the released word is the old one, and whether the new word then arrives clean, with no bit 10 and no `irq_err` pulse.

// File: rtl/serial_rx_tagq.sv
module serial_rx_tagq #(
  parameter int OVS      = 16,
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baud_tick,
  input  logic        rx_line,
  input  logic        cfg_fifo_mode,
  input  logic        cfg_len8,
  input  logic        cfg_msb_first,
  input  logic [1:0]  cfg_parity,
  input  logic        cfg_two_stop,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  output logic        irq_done,
  output logic        irq_err,
  output logic        irq_timeout
);
  localparam int CW = $clog2(OVS);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = $clog2(TO_CHARS * OVS * 12 + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t state;

  logic [CW-1:0] cnt;
  logic [2:0]    bit_i;
  logic [7:0]    shreg;
  logic          par_acc, pe_q, fe_q, stop_i;
  logic [15:0]   hold_q;
  logic          hold_full;
  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic [TW-1:0] to_cnt;

  wire           samp       = baud_tick && (cnt == LAST);
  wire [2:0]     last_bit   = cfg_len8 ? 3'd7 : 3'd6;
  wire [2:0]     put_idx    = cfg_msb_first ? last_bit - bit_i : bit_i;
  wire           parity_on  = cfg_parity != 2'b00;
  wire           done_now   = samp && (state == S_STOP) && (stop_i == cfg_two_stop);
  wire           fe_now     = fe_q | ~rx_line;
  wire           full       = count == (AW+1)'(DEPTH);
  wire           pop        = rd_en && rd_valid;
  wire           q_pop      = pop && cfg_fifo_mode;
  wire           q_push     = done_now && cfg_fifo_mode && (!full || pop);
  wire           q_ovf      = done_now && cfg_fifo_mode && full && !pop;
  wire           single_ovr = done_now && !cfg_fifo_mode && hold_full && !pop;
  wire [AW-1:0]  tail       = wp - 1'b1;
  wire [15:0]    new_word   = {5'b0, single_ovr, fe_now, pe_q, shreg};
  wire           to_arm     = cfg_fifo_mode && (count != '0) && (state == S_IDLE) && !rd_en;
  wire [TW-1:0]  to_limit   = TW'(TO_CHARS * OVS) *
                              (TW'(9) + TW'(cfg_len8) + TW'(parity_on) + TW'(cfg_two_stop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bit_i   <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      stop_i  <= 1'b0;
    end else if (baud_tick) begin
      case (state)
        S_IDLE:
          if (!rx_line) begin
            state <= S_START;
            cnt   <= '0;
          end
        S_START:
          if (cnt == MID) begin
            cnt <= '0;
            if (rx_line) state <= S_IDLE;
            else begin
              state   <= S_DATA;
              bit_i   <= '0;
              shreg   <= '0;
              par_acc <= 1'b0;
              pe_q    <= 1'b0;
              fe_q    <= 1'b0;
              stop_i  <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (samp) begin
            cnt            <= '0;
            shreg[put_idx] <= rx_line;
            par_acc        <= par_acc ^ rx_line;
            bit_i          <= bit_i + 1'b1;
            if (bit_i == last_bit) state <= parity_on ? S_PAR : S_STOP;
          end else cnt <= cnt + 1'b1;
        S_PAR:
          if (samp) begin
            cnt <= '0;
            case (cfg_parity)
              2'b01:   pe_q <= ~(par_acc ^ rx_line);
              2'b10:   pe_q <= par_acc ^ rx_line;
              default: pe_q <= rx_line;
            endcase
            state <= S_STOP;
          end else cnt <= cnt + 1'b1;
        S_STOP:
          if (samp) begin
            cnt  <= '0;
            fe_q <= fe_now;
            if (stop_i == cfg_two_stop) state <= S_IDLE;
            else stop_i <= 1'b1;
          end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (done_now && !cfg_fifo_mode) begin
      hold_q    <= new_word;
      hold_full <= 1'b1;
    end else if (pop && !cfg_fifo_mode) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (q_push) wp <= wp + 1'b1;
      if (q_pop)  rp <= rp + 1'b1;
      count <= count + (AW+1)'(q_push) - (AW+1)'(q_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (q_push)     mem[wp]       <= new_word;
    else if (q_ovf) mem[tail][10] <= 1'b1;
  end

  assign rd_valid = cfg_fifo_mode ? (count != '0) : hold_full;
  assign rd_data  = !rd_valid ? 16'h0 : (cfg_fifo_mode ? mem[rp] : hold_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_done    <= 1'b0;
      irq_err     <= 1'b0;
      irq_timeout <= 1'b0;
      to_cnt      <= '0;
    end else begin
      irq_done    <= done_now;
      irq_err     <= done_now && (pe_q || fe_now || single_ovr || q_ovf);
      irq_timeout <= to_arm && baud_tick && (to_cnt == to_limit - 1'b1);
      if (!to_arm) to_cnt <= '0;
      else if (baud_tick && to_cnt != to_limit) to_cnt <= to_cnt + 1'b1;
    end
  end

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> irq_done);
  assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);
  assert_timeout_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timeout |-> count != '0);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
  assert_full_stays_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_ovf |=> count == (AW+1)'(DEPTH));
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:11] == 5'b0);
endmodule

// File: tb/sim_serial_rx_tagq.sv
module sim_serial_rx_tagq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, fifo_m = 1'b0, len8 = 1'b1;
  logic msb = 1'b0, two_stop = 1'b0, rd_en = 1'b0;
  logic [1:0] par = 2'b00;
  wire [15:0] rd_data;
  wire rd_valid, irq_done, irq_err, irq_to;
  int n_cmp = 0, n_bad = 0, n_done = 0, n_err = 0, n_to = 0, exp_done = 0, exp_err = 0;
  time t_done = 0, t_to = 0;
  logic [15:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_tagq u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .rx_line(rx),
    .cfg_fifo_mode(fifo_m), .cfg_len8(len8), .cfg_msb_first(msb),
    .cfg_parity(par), .cfg_two_stop(two_stop), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq_done(irq_done),
    .irq_err(irq_err), .irq_timeout(irq_to));

  always @(negedge clk) if (rst_n) begin
    if (irq_done) begin n_done++; t_done = $time; end
    if (irq_err) n_err++;
    if (irq_to) begin n_to++; t_to = $time; end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int frame_bits();
    return 1 + (len8 ? 8 : 7) + ((par != 2'b00) ? 1 : 0) + (two_stop ? 2 : 1);
  endfunction

  task automatic send(logic [7:0] d, bit bp, bit bs1, bit bs2);
    logic fb[0:12];
    int nb = 0, len = len8 ? 8 : 7;
    logic [7:0] dd = len8 ? d : {1'b0, d[6:0]};
    logic p;
    bit fe, pe;
    fb[nb++] = 1'b0;
    for (int i = 0; i < len; i++) fb[nb++] = dd[msb ? len - 1 - i : i];
    case (par)
      2'b01:   p = ~^dd;
      2'b10:   p = ^dd;
      default: p = 1'b0;
    endcase
    if (bp) p = ~p;
    if (par != 2'b00) fb[nb++] = p;
    fb[nb++] = ~bs1;
    if (two_stop) fb[nb++] = ~bs2;
    pe = (par != 2'b00) && bp;
    fe = bs1 || (two_stop && bs2);
    q.push_back({5'b0, 1'b0, fe, pe, dd});
    exp_done++;
    if (pe || fe) exp_err++;
    @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx = fb[i];
      repeat (16) @(negedge clk);
    end
    rx = 1'b1;
  endtask

  task automatic read_one(string tag);
    logic [15:0] e;
    @(negedge clk);
    chk({tag, " valid"}, rd_valid, 1);
    if (q.size() != 0) begin
      e = q.pop_front();
      chk(tag, rd_data, e);
    end
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send_with_read(logic [7:0] d, string tag);
    logic [15:0] e;
    fork
      send(d, 0, 0, 0);
      begin
        @(negedge clk);
        repeat (8 + 16 * (frame_bits() - 1)) @(posedge clk);
        @(negedge clk);
        e = q.pop_front();
        chk(tag, rd_data, e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
      end
    join
  endtask

  task automatic do_reset(bit fm);
    rst_n = 1'b0; fifo_m = fm; len8 = 1'b1; msb = 1'b0; par = 2'b00;
    two_stop = 1'b0; rx = 1'b1; rd_en = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset(0);
    @(negedge clk);
    chk("R11 rd_valid", rd_valid, 0);
    chk("R11 rd_data", rd_data, 0);
    chk("R11 irqs", {irq_done, irq_err, irq_to}, 0);

    send(8'hA5, 0, 0, 0); read_one("R2 lsb-first 8 bit");
    msb = 1'b1;
    send(8'h3C, 0, 0, 0); read_one("R2 msb-first 8 bit");
    len8 = 1'b0;
    send(8'hFF, 0, 0, 0); read_one("R2 7 bit zero-extended msb");
    msb = 1'b0;
    send(8'hC6, 0, 0, 0); read_one("R2 7 bit lsb");
    len8 = 1'b1;

    par = 2'b01;
    send(8'h12, 0, 0, 0); read_one("R3 odd parity good");
    send(8'h34, 1, 0, 0); read_one("R3 odd parity bad");
    par = 2'b10;
    send(8'h77, 1, 0, 0); read_one("R3 even parity bad");
    par = 2'b11;
    send(8'h0F, 0, 0, 0); read_one("R3 forced zero good");
    send(8'h0F, 1, 0, 0); read_one("R3 forced zero bad");
    par = 2'b00;

    send(8'h55, 0, 1, 0); read_one("R4 single stop low");
    two_stop = 1'b1;
    send(8'h66, 0, 0, 1); read_one("R4 second stop low");
    send(8'h67, 0, 0, 0); read_one("R4 two stops good");
    two_stop = 1'b0;
    chk("R9 error pulses", n_err, exp_err);

    @(negedge clk); rx = 1'b0;
    repeat (5) @(negedge clk); rx = 1'b1;
    repeat (200) @(negedge clk);
    chk("R1 glitch no completion", n_done, exp_done);
    chk("R1 glitch nothing stored", rd_valid, 0);

    send(8'h21, 0, 0, 0);
    send(8'h43, 0, 0, 0);
    void'(q.pop_front());
    q[0] = q[0] | 16'h0400;
    exp_err++;
    read_one("R5 overrun replaces and flags");
    chk("R5 overrun error pulse", n_err, exp_err);

    send(8'h9A, 0, 0, 0);
    send_with_read(8'hBC, "R6 single read at completion old word");
    read_one("R6 single new word clean");
    chk("R6 no error pulse", n_err, exp_err);

    send(8'h11, 0, 0, 0);
    repeat (800) @(negedge clk);
    chk("R10 no timeout in single mode", n_to, 0);
    read_one("R10 single word");
    chk("R9 done pulses single", n_done, exp_done);

    do_reset(1);
    send(8'h5A, 0, 0, 0);
    repeat (700) @(negedge clk);
    chk("R10 timeout pulses once", n_to, 1);
    chk("R10 timeout delay", 32'((t_to - t_done) / CLK_PERIOD), 32'(4 * 16 * frame_bits()));
    read_one("R10 queued word");

    par = 2'b01;
    send(8'h01, 0, 0, 0);
    send(8'h02, 1, 0, 0);
    send(8'h03, 0, 1, 0);
    send(8'h04, 1, 1, 0);
    par = 2'b00;
    for (int i = 0; i < 4; i++) read_one("R7 order and per-word flags");
    chk("R7 queue empty", rd_valid, 0);

    do_reset(1);
    for (int i = 0; i < 17; i++) send(8'(8'h40 + i), 0, 0, 0);
    void'(q.pop_back());
    q[$] = q[$] | 16'h0400;
    exp_err++;
    chk("R8 overflow error pulse", n_err, exp_err);
    for (int i = 0; i < 16; i++) read_one("R8 overflow keeps sixteen");
    @(negedge clk);
    chk("R8 extra word discarded", rd_valid, 0);

    do_reset(1);
    for (int i = 0; i < 16; i++) send(8'(8'h60 + i), 0, 0, 0);
    send_with_read(8'h7F, "R6 full queue pop at completion");
    for (int i = 0; i < 16; i++) read_one("R6 full queue accepts new word");
    chk("R6 no overflow pulse", n_err, exp_err);
    chk("R9 done pulses total", n_done, exp_done);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule